// File: doc/BRIEF.md
# SDRAM Data Path with CAS Latency and Byte Masks

This block sits beside an SDRAM command engine and owns the data side of the memory interface: the 64-bit data bus (split into a driven half, an output enable and a sampled half for the pad ring) and the eight byte-mask lines. The command engine tells it, cycle by cycle, when a write beat or a read beat is being issued and when a burst is being stopped. The block handles the rest.

For writes, the data and the byte mask go onto the pins in the same cycle as the beat. For reads, the data is sampled from the bus a programmable CAS latency of 2 or 3 cycles after the beat was issued. It is then registered, and each byte lane is flagged valid or invalid. A read byte mask given in one cycle blanks its lanes two cycles later, when the matching data is on the bus. Write drive is held off while read data is on the bus and for one cycle after it, so the bus always turns around with a gap.

Top module: `sdram_dq_path`

## Requirements
- R1: While reset is active and in the first cycle after it, rd_valid, rd_lane_vld and rd_data are all zero.
- R2: A write beat (wr_beat=1, burst_stop=0) that is not held off by R9 sets dq_oe=1 in the same cycle. In that cycle dq_o equals wr_data and dqm equals wr_mask, so the write mask latency is 0.
- R3: In any cycle without a driven write beat, dq_oe=0 and dq_o is all zeros.
- R4: A read beat (rd_beat=1, burst_stop=0) issued in cycle c has its bus data in cycle c+L, where L is the selected CAS latency. The value of dq_i in cycle c+L appears on rd_data, with rd_valid=1, in cycle c+L+1.
- R5: cas_lat=2 selects latency 2, and any other value selects latency 3.
- R6: The read mask has a latency of 2. If rd_mask bit i is 1 in cycle m, the beat whose bus cycle is m+2 has bit i of rd_lane_vld at 0 and bits [8i+7:8i] of rd_data at 0. An unmasked lane has its flag at 1 and carries its data.
- R7: In any cycle without a driven write beat, dqm equals rd_mask.
- R8: A cycle with burst_stop=1 issues no read beat and drives no write beat, whatever rd_beat and wr_beat are. As a result, at most L-1 read beats become valid after a stop.
- R9: A write beat is not driven (dq_oe=0) in a cycle whose bus carries read data, nor in the cycle right after such a cycle.
- R10: In any cycle with rd_valid=0, rd_lane_vld and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cas_lat | input | 2 | CAS latency select: 2, or any other value for 3 |
| rd_beat | input | 1 | Read beat issued this cycle |
| wr_beat | input | 1 | Write beat issued this cycle |
| burst_stop | input | 1 | Burst stop this cycle; cancels any beat in the same cycle |
| wr_data | input | 64 | Write beat data |
| wr_mask | input | 8 | Write byte mask, 1 blocks the lane |
| rd_mask | input | 8 | Read byte mask, applies two cycles later |
| dq_i | input | 64 | Sampled data bus |
| dq_o | output | 64 | Driven data bus value |
| dq_oe | output | 1 | Data bus output enable |
| dqm | output | 8 | Byte mask pins |
| rd_valid | output | 1 | Registered read beat valid |
| rd_data | output | 64 | Registered read data, with masked lanes zeroed |
| rd_lane_vld | output | 8 | Per-lane valid flags for the read beat |

## Verification
The assertions check on every cycle the pin-level rules. These are: write data and mask appear together with the enable, there is no drive in a stop cycle, no drive while read data is valid or in the cycle after, lane flags and data are zero when idle, and read validity and lane flags match the beat and mask issued three or four cycles earlier. The bench scenarios show the rest: that the captured data is exactly the bus value from the right cycle with the right lanes cleared, that an unusual latency code falls back to 3, and that dense read and write mixes with stops produce the expected held-off writes.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;
   // cycles from a read mask sample to the bus cycle it blanks
   localparam int RD_MASK_LAT = 2;

   function automatic int lanes_of(input int data_w, input int lane_w);
      return data_w / lane_w;
   endfunction
endpackage

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
   import sdram_dq_pkg::*;
#(
   parameter int MIN_CL = 2,
   parameter int MAX_CL = 3,
   parameter int LANES  = 8,
   parameter int CL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [CL_W-1:0]  cas_lat,
   input  logic [LANES-1:0] rd_mask,
   output logic             bus_rd,
   output logic             bus_rd_prev,
   output logic [LANES-1:0] bus_mask
);
   logic [MAX_CL-1:0] vsr;
   logic [LANES-1:0]  mdly [RD_MASK_LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) vsr <= '0;
      else        vsr <= {vsr[MAX_CL-2:0], issue};
   end

   assign bus_rd = (cas_lat == CL_W'(MIN_CL)) ? vsr[MIN_CL-1] : vsr[MAX_CL-1];

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rd_prev <= 1'b0;
      else        bus_rd_prev <= bus_rd;
   end

   for (genvar k = 0; k < RD_MASK_LAT; k++) begin : g_mdly
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) mdly[k] <= '0;
            else        mdly[k] <= rd_mask;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) mdly[k] <= '0;
            else        mdly[k] <= mdly[k-1];
         end
      end
   end

   assign bus_mask = mdly[RD_MASK_LAT-1];
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int LANES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic [LANES-1:0]  bus_mask,
   input  logic [DATA_W-1:0] dq_i,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [LANES-1:0]  rd_lane_vld
);
   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= bus_rd;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic keep;
      assign keep = bus_rd & ~bus_mask[i];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_lane_vld[i]                <= 1'b0;
            rd_data[i*LANE_W +: LANE_W]   <= '0;
         end else begin
            rd_lane_vld[i]                <= keep;
            rd_data[i*LANE_W +: LANE_W]   <= keep ? dq_i[i*LANE_W +: LANE_W] : '0;
         end
      end
   end
endmodule

// File: rtl/sdram_wr_drive.sv
module sdram_wr_drive #(
   parameter int DATA_W = 64,
   parameter int LANES  = 8
) (
   input  logic              wr_beat,
   input  logic              burst_stop,
   input  logic              bus_rd,
   input  logic              bus_rd_prev,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_mask,
   input  logic [LANES-1:0]  rd_mask,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [LANES-1:0]  dqm
);
   logic drive;

   always_comb begin
      drive = wr_beat & ~burst_stop & ~bus_rd & ~bus_rd_prev;
      dq_oe = drive;
      dq_o  = drive ? wr_data : '0;
      dqm   = drive ? wr_mask : rd_mask;
   end
endmodule

// File: rtl/sdram_dq_path.sv
module sdram_dq_path
   import sdram_dq_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int MIN_CL = 2,
   parameter int MAX_CL = 3,
   localparam int LANES = lanes_of(DATA_W, LANE_W),
   localparam int CL_W  = $clog2(MAX_CL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CL_W-1:0]   cas_lat,
   input  logic              rd_beat,
   input  logic              wr_beat,
   input  logic              burst_stop,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_mask,
   input  logic [LANES-1:0]  rd_mask,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [LANES-1:0]  dqm,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [LANES-1:0]  rd_lane_vld
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (MIN_CL < 1 || MAX_CL <= MIN_CL) begin : g_bad_cl
      $error("latency range must satisfy 1 <= MIN_CL < MAX_CL");
   end

   logic             issue;
   logic             bus_rd;
   logic             bus_rd_prev;
   logic [LANES-1:0] bus_mask;

   assign issue = rd_beat & ~burst_stop;

   sdram_rd_pipe #(
      .MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .LANES(LANES), .CL_W(CL_W)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .issue(issue), .cas_lat(cas_lat),
      .rd_mask(rd_mask), .bus_rd(bus_rd), .bus_rd_prev(bus_rd_prev),
      .bus_mask(bus_mask)
   );

   sdram_rd_capture #(
      .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_mask(bus_mask),
      .dq_i(dq_i), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_lane_vld(rd_lane_vld)
   );

   sdram_wr_drive #(
      .DATA_W(DATA_W), .LANES(LANES)
   ) u_drv (
      .wr_beat(wr_beat), .burst_stop(burst_stop), .bus_rd(bus_rd),
      .bus_rd_prev(bus_rd_prev), .wr_data(wr_data), .wr_mask(wr_mask),
      .rd_mask(rd_mask), .dq_o(dq_o), .dq_oe(dq_oe), .dqm(dqm)
   );
endmodule

// File: rtl/sdram_dq_chk.sv
module sdram_dq_chk #(
   parameter int DATA_W = 64,
   parameter int LANES  = 8,
   parameter int CL_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CL_W-1:0]   cas_lat,
   input logic              rd_beat,
   input logic              wr_beat,
   input logic              burst_stop,
   input logic [DATA_W-1:0] wr_data,
   input logic [LANES-1:0]  wr_mask,
   input logic [LANES-1:0]  rd_mask,
   input logic [DATA_W-1:0] dq_o,
   input logic              dq_oe,
   input logic [LANES-1:0]  dqm,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic [LANES-1:0]  rd_lane_vld
);
   // R2
   wr_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (dqm == wr_mask && dq_o == wr_data));
   // R3
   oe_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> wr_beat);
   // R3
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> dq_o == '0);
   // R8
   stop_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_stop |-> !dq_oe);
   // R9
   turn_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !rd_valid);
   // R9
   turn_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |=> !rd_valid);
   // R4
   lat_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && cas_lat == CL_W'(2)) |-> $past(rd_beat && !burst_stop, 3));
   // R5
   lat_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && cas_lat != CL_W'(2)) |-> $past(rd_beat && !burst_stop, 4));
   // R6
   mask_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_lane_vld == ~$past(rd_mask, 3));
   // R10
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_lane_vld == '0 && rd_data == '0));
   // R7
   dqm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> dqm == rd_mask);
endmodule

bind sdram_dq_path sdram_dq_chk #(
   .DATA_W(DATA_W), .LANES(LANES), .CL_W(CL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat),
   .wr_beat(wr_beat), .burst_stop(burst_stop), .wr_data(wr_data),
   .wr_mask(wr_mask), .rd_mask(rd_mask), .dq_o(dq_o), .dq_oe(dq_oe),
   .dqm(dqm), .rd_valid(rd_valid), .rd_data(rd_data),
   .rd_lane_vld(rd_lane_vld)
);

// File: tb/sim_sdram_dq_path.sv
module sim_sdram_dq_path;
   localparam int HN = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cas_lat = 2'd2;
   logic        rd_beat = 1'b0, wr_beat = 1'b0, burst_stop = 1'b0;
   logic [63:0] wr_data = '0, dq_i = '0;
   logic [7:0]  wr_mask = '0, rd_mask = '0;
   logic [63:0] dq_o, rd_data;
   logic        dq_oe, rd_valid;
   logic [7:0]  dqm, rd_lane_vld;

   int total = 0;
   int bad = 0;
   bit done = 0;

   bit          iss_h [HN];
   logic [7:0]  msk_h [HN];
   logic [63:0] dq_h  [HN];

   always #10 clk = ~clk;

   sdram_dq_path u0 (
      .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat),
      .wr_beat(wr_beat), .burst_stop(burst_stop), .wr_data(wr_data),
      .wr_mask(wr_mask), .rd_mask(rd_mask), .dq_i(dq_i), .dq_o(dq_o),
      .dq_oe(dq_oe), .dqm(dqm), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_lane_vld(rd_lane_vld)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] widen(input logic [7:0] lanes);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = {8{lanes[i]}};
      return r;
   endfunction

   function automatic bit bus_at(input int k, input int l);
      return (k >= l) ? iss_h[k-l] : 1'b0;
   endfunction

   task automatic run_scn(input logic [1:0] cl, input int seed_in, input int ncyc, input int mode);
      int unsigned seed = seed_in;
      int l = (cl == 2'd2) ? 2 : 3;
      @(negedge clk);
      rst_n = 1'b0;
      rd_beat = 0; wr_beat = 0; burst_stop = 0; rd_mask = 0;
      cas_lat = cl;
      for (int k = 0; k < HN; k++) begin iss_h[k] = 0; msk_h[k] = 0; dq_h[k] = 0; end
      repeat (3) @(negedge clk);
      for (int n = 0; n < ncyc; n++) begin
         logic r, w, s;
         logic [7:0] m, wm;
         logic [63:0] wd, dv;
         bit ev, coll;
         logic [7:0] el;
         if (n > 0) @(negedge clk);
         ev = (n >= l + 1) ? iss_h[n-l-1] : 1'b0;
         el = ev ? ~msk_h[n-3] : 8'h00;
         if (n == 0) begin
            chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
            chk("R1 rd_lane_vld", {56'd0, rd_lane_vld}, 64'd0);
            chk("R1 rd_data", rd_data, 64'd0);
         end else if (ev) begin
            chk((cl == 2'd2 || cl == 2'd3) ? "R4 rd_valid" : "R5 rd_valid", {63'd0, rd_valid}, 64'd1);
            chk("R6 rd_lane_vld", {56'd0, rd_lane_vld}, {56'd0, el});
            chk("R6 rd_data", rd_data, dq_h[n-1] & widen(el));
         end else begin
            chk("R4 rd_valid idle", {63'd0, rd_valid}, 64'd0);
            chk("R10 idle lanes", {56'd0, rd_lane_vld}, 64'd0);
            chk("R10 idle data", rd_data, 64'd0);
         end
         seed = seed * 1103515245 + 12345;
         case (mode)
            0: begin
               r = (seed[20:18] < 3);
               w = (seed[23:21] < 3);
               s = (seed[26:24] == 0);
            end
            1: begin
               r = (n % 8) < 4;
               w = (n % 8) == 7;
               s = r && (seed[27:25] == 0);
            end
            default: begin
               r = (n % 6) < 3;
               w = (n % 6) >= 3;
               s = (seed[28:25] == 0);
            end
         endcase
         m  = seed[30:29] == 0 ? seed[7:0] : 8'h00;
         wm = seed[15:8];
         wd = {seed, ~seed} ^ {32'(n), 32'(n * 7)};
         dv = {32'(n) * 32'h9E3779B1, ~(32'(n) * 32'h85EBCA6B)};
         rst_n = 1'b1;
         rd_beat = r; wr_beat = w; burst_stop = s;
         rd_mask = m; wr_mask = wm; wr_data = wd; dq_i = dv;
         iss_h[n] = r & ~s;
         msk_h[n] = m;
         dq_h[n]  = dv;
         #1;
         coll = bus_at(n, l) || (n >= 1 && bus_at(n-1, l));
         if (w && !s && !coll) begin
            chk("R2 dq_oe", {63'd0, dq_oe}, 64'd1);
            chk("R2 dq_o", dq_o, wd);
            chk("R2 dqm", {56'd0, dqm}, {56'd0, wm});
         end else begin
            chk(s ? "R8 dq_oe" : (w ? "R9 dq_oe" : "R3 dq_oe"), {63'd0, dq_oe}, 64'd0);
            chk("R3 dq_o", dq_o, 64'd0);
            chk("R7 dqm", {56'd0, dqm}, {56'd0, m});
         end
      end
      @(negedge clk);
      rd_beat = 0; wr_beat = 0; burst_stop = 0;
   endtask

   initial begin
      run_scn(2'd2, 11, 400, 0);
      run_scn(2'd3, 23, 400, 0);
      run_scn(2'd2, 37, 300, 1);
      run_scn(2'd3, 41, 300, 1);
      run_scn(2'd1, 53, 300, 0);
      run_scn(2'd0, 59, 200, 2);
      run_scn(2'd2, 61, 300, 2);
      run_scn(2'd3, 67, 300, 2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule